// File: doc/BRIEF.md
# Video Stream Geometry and Rate Measurer

The block observes a pixel-parallel video image stream that has no horizontal or vertical sync pulses. Single-cycle markers give the start and end of each active line and each active frame, and a valid bit per pixel lane says which lanes carry active pixels in a cycle. From these the block measures the active line width in pixels, the number of active lines per frame and the interlace field of each frame. It also measures the line period in clock cycles and turns it into a stream clock ratio value.

The ratio value is `htotal_i * 32768 / line_period`, computed by a sequential restoring divider that runs once per accepted line start while it is idle. The horizontal total is the only software-set timing value the block uses. Other timing attributes (vertical total, sync positions and widths, start offsets) go in on one bus and come out unchanged. Two protocol faults latch a sticky error: a line start inside an open line, and a line period of zero after the period counter wraps. Once the error is set, every measurement output holds its value.

Top module: `vid_geom_meas`

## Requirements
- R1: At each end of line inside an open line, `width_o` takes the number of set valid bits over all cycles from that line's start to its end, both included. Cycles with no valid bit set add nothing. Valid bits outside an open line are ignored. A cycle with both start and end of line is a complete one-cycle line.
- R2: Valid bit i marks lane i, that is pixel N+i of the beat, as active. A partial last beat (for example `0001` or `0011` with four lanes) adds only its set bits, so widths that are not a multiple of the lane count are measured exactly.
- R3: At each end of frame inside an open frame (or in the cycle of its start of frame), `height_o` takes the number of line ends that fell inside the frame. `upd_stb_o` is high for exactly the one cycle after that edge.
- R4: `field_o` takes `field_i` only in a cycle with start of frame asserted. 1 means top field. `field_i` has no effect in any other cycle.
- R5: From the second line start after reset, `period_o` takes the number of clock cycles since the previous line start, modulo 2^PER_W.
- R6: An accepted line start, with the divider idle, starts a division that gives `floor(htotal_i*32768/period)`. `htotal_i` is sampled in that cycle. `rate_busy_o` is high for DIV_W cycles. `rate_o` updates and `rate_stb_o` pulses for one cycle DIV_W cycles after the start edge. A line start while busy starts nothing.
- R7: `err_o` becomes 1 and stays 1 until reset on either of two faults: a line start while a line is open, or a measured period of 0. From the faulting cycle onward, width, height, field, period and rate hold their values and both strobes stay low.
- R8: `attr_o` always equals `attr_i`.
- R9: After reset all outputs except `attr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stream clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | LANES | Per-lane active-pixel flags |
| sol_i | input | 1 | Start of line marker |
| eol_i | input | 1 | End of line marker |
| sof_i | input | 1 | Start of frame marker |
| eof_i | input | 1 | End of frame marker |
| field_i | input | 1 | Field flag, sampled with start of frame |
| htotal_i | input | HT_W | Programmed horizontal total |
| attr_i | input | ATTR_W | Unused timing attributes |
| attr_o | output | ATTR_W | Same attributes, unchanged |
| width_o | output | CNT_W | Active pixels per line |
| height_o | output | CNT_W | Active lines per frame |
| field_o | output | 1 | Field of last frame |
| upd_stb_o | output | 1 | Frame measurement update pulse |
| period_o | output | PER_W | Line period in cycles |
| rate_o | output | HT_W+15 | Clock ratio value |
| rate_stb_o | output | 1 | Ratio update pulse |
| rate_busy_o | output | 1 | Divider running |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with four lanes, so partial last beats and one-beat lines are exercised. A 6-bit period counter lets a 64-cycle line period wrap to zero and reach the zero-period fault in a short run. An 8-bit horizontal total keeps the divider at 23 cycles. The bench also sends short line periods, so that line starts arrive while the divider is busy and are dropped.

// File: rtl/vgm_pkg.sv
package vgm_pkg;
  localparam int unsigned RATE_SHIFT = 15;

  function automatic int unsigned pop_w(int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/vgm_span_acc.sv
// Counts weighted events across an open span (line or frame); latches on close.
module vgm_span_acc #(
  parameter int unsigned IN_W  = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [IN_W-1:0]  inc_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] total_o,
  output logic             stb_o,
  output logic             active_o,
  output logic             close_ok_o
);
  logic             in_span_q;
  logic [CNT_W-1:0] acc_q;
  logic             act;
  logic [CNT_W-1:0] sum;

  assign act        = in_span_q | open_i;
  assign sum        = (open_i ? '0 : acc_q) + (act ? CNT_W'(inc_i) : '0);
  assign close_ok_o = close_i & act;
  assign active_o   = in_span_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_span_q <= 1'b0;
      acc_q     <= '0;
      total_o   <= '0;
      stb_o     <= 1'b0;
    end else begin
      stb_o     <= 1'b0;
      in_span_q <= act & ~close_i;
      acc_q     <= sum;
      if (close_ok_o && !hold_i) begin
        total_o <= sum;
        stb_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vgm_period.sv
module vgm_period #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sol_i,
  input  logic             hold_i,
  output logic [PER_W-1:0] cur_o,
  output logic             seen_o,
  output logic             zero_o,
  output logic [PER_W-1:0] period_o
);
  logic [PER_W-1:0] cnt_q;
  logic             seen_q;

  assign cur_o  = cnt_q;
  assign seen_o = seen_q;
  assign zero_o = seen_q & sol_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      period_o <= '0;
    end else begin
      cnt_q <= sol_i ? PER_W'(1) : cnt_q + PER_W'(1);
      if (sol_i) seen_q <= 1'b1;
      if (sol_i && seen_q && !hold_i) period_o <= cnt_q;
    end
  end
endmodule

// File: rtl/vgm_div.sv
// Restoring divider, one quotient bit per cycle.
module vgm_div #(
  parameter int unsigned DIV_W = 31,
  parameter int unsigned DSR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] dvd_i,
  input  logic [DSR_W-1:0] dsr_i,
  input  logic             hold_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DIV_W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] quo_q, quo_nx;
  logic [DSR_W-1:0] rem_q, dsr_q, rem_nx;
  logic [DSR_W:0]   rem_sh, diff;
  logic [CW-1:0]    cnt_q;
  logic             ge;

  assign rem_sh = {rem_q, quo_q[DIV_W-1]};
  assign diff   = rem_sh - {1'b0, dsr_q};
  assign ge     = rem_sh >= {1'b0, dsr_q};
  assign rem_nx = ge ? diff[DSR_W-1:0] : rem_sh[DSR_W-1:0];
  assign quo_nx = {quo_q[DIV_W-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          quo_q  <= dvd_i;
          rem_q  <= '0;
          dsr_q  <= dsr_i;
          cnt_q  <= CW'(DIV_W);
        end
      end else begin
        quo_q <= quo_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          if (!hold_i) begin
            quo_o  <= quo_nx;
            done_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vid_geom_meas.sv
module vid_geom_meas #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned HT_W   = 16,
  parameter int unsigned ATTR_W = 64,
  localparam int unsigned DIV_W = HT_W + vgm_pkg::RATE_SHIFT,
  localparam int unsigned POP_W = vgm_pkg::pop_w(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  valid_i,
  input  logic              sol_i,
  input  logic              eol_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              field_i,
  input  logic [HT_W-1:0]   htotal_i,
  input  logic [ATTR_W-1:0] attr_i,
  output logic [ATTR_W-1:0] attr_o,
  output logic [CNT_W-1:0]  width_o,
  output logic [CNT_W-1:0]  height_o,
  output logic              field_o,
  output logic              upd_stb_o,
  output logic [PER_W-1:0]  period_o,
  output logic [DIV_W-1:0]  rate_o,
  output logic              rate_stb_o,
  output logic              rate_busy_o,
  output logic              err_o
);
  logic [POP_W-1:0] pop;
  logic             in_line, eol_ok, in_frame, eof_ok, line_stb;
  logic             seen, zero, err_q, err_set, hold, div_start;
  logic [PER_W-1:0] cur_per;

  always_comb begin
    pop = '0;
    for (int i = 0; i < LANES; i++) pop = pop + POP_W'(valid_i[i]);
  end

  assign attr_o = attr_i;

  assign err_set   = (sol_i & in_line) | zero;
  assign hold      = err_q | err_set;
  assign err_o     = err_q;
  assign div_start = sol_i & seen & ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      field_o <= 1'b0;
    end else begin
      if (err_set) err_q <= 1'b1;
      if (sof_i && !hold) field_o <= field_i;
    end
  end

  vgm_span_acc #(.IN_W(POP_W), .CNT_W(CNT_W)) u_line (
    .clk_i, .rst_ni,
    .open_i(sol_i), .close_i(eol_i), .inc_i(pop), .hold_i(hold),
    .total_o(width_o), .stb_o(line_stb), .active_o(in_line), .close_ok_o(eol_ok)
  );

  vgm_span_acc #(.IN_W(1), .CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni,
    .open_i(sof_i), .close_i(eof_i), .inc_i(eol_ok), .hold_i(hold),
    .total_o(height_o), .stb_o(upd_stb_o), .active_o(in_frame), .close_ok_o(eof_ok)
  );

  vgm_period #(.PER_W(PER_W)) u_per (
    .clk_i, .rst_ni,
    .sol_i, .hold_i(hold),
    .cur_o(cur_per), .seen_o(seen), .zero_o(zero), .period_o
  );

  vgm_div #(.DIV_W(DIV_W), .DSR_W(PER_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start),
    .dvd_i({htotal_i, {vgm_pkg::RATE_SHIFT{1'b0}}}),
    .dsr_i(cur_per), .hold_i(hold),
    .busy_o(rate_busy_o), .done_o(rate_stb_o), .quo_o(rate_o)
  );

  logic unused;
  assign unused = line_stb ^ in_frame ^ eof_ok;
endmodule

// File: rtl/vgm_checker.sv
module vgm_checker #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PER_W = 16,
  parameter int unsigned DIV_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sol_i,
  input logic             eof_i,
  input logic [CNT_W-1:0] width_o,
  input logic [CNT_W-1:0] height_o,
  input logic             field_o,
  input logic             upd_stb_o,
  input logic [PER_W-1:0] period_o,
  input logic [DIV_W-1:0] rate_o,
  input logic             rate_stb_o,
  input logic             rate_busy_o,
  input logic             err_o
);
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_hold_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(width_o) && $stable(height_o) && $stable(field_o) &&
               $stable(period_o) && $stable(rate_o) && !upd_stb_o && !rate_stb_o));

  assert_stb_after_eof_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_o |-> $past(eof_i));

  assert_busy_from_sol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rate_busy_o) |-> $past(sol_i));

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_stb_o |-> !rate_busy_o);

  assert_period_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o != $past(period_o)) |-> (period_o != '0));
endmodule

bind vid_geom_meas vgm_checker #(.CNT_W(CNT_W), .PER_W(PER_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sol_i(sol_i), .eof_i(eof_i),
  .width_o(width_o), .height_o(height_o), .field_o(field_o), .upd_stb_o(upd_stb_o),
  .period_o(period_o), .rate_o(rate_o), .rate_stb_o(rate_stb_o),
  .rate_busy_o(rate_busy_o), .err_o(err_o)
);

// File: tb/vid_geom_meas_test.sv
`timescale 1ns/1ps
module vid_geom_meas_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4, CNT_W = 12, PER_W = 6, HT_W = 8, ATTR_W = 16;
  localparam int DIV_W = HT_W + 15;

  logic clk = 0, rst_n = 0;
  logic [LANES-1:0] valid = 0;
  logic sol = 0, eol = 0, sof = 0, eof = 0, fld = 0;
  logic [HT_W-1:0] ht = 8'd100;
  logic [ATTR_W-1:0] attr = 0;
  logic [ATTR_W-1:0] attr_o;
  logic [CNT_W-1:0] width_o, height_o;
  logic field_o, upd_stb_o, rate_stb_o, rate_busy_o, err_o;
  logic [PER_W-1:0] period_o;
  logic [DIV_W-1:0] rate_o;

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_geom_meas #(.LANES(LANES), .CNT_W(CNT_W), .PER_W(PER_W), .HT_W(HT_W), .ATTR_W(ATTR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sol_i(sol), .eol_i(eol),
    .sof_i(sof), .eof_i(eof), .field_i(fld), .htotal_i(ht), .attr_i(attr), .attr_o(attr_o),
    .width_o(width_o), .height_o(height_o), .field_o(field_o), .upd_stb_o(upd_stb_o),
    .period_o(period_o), .rate_o(rate_o), .rate_stb_o(rate_stb_o),
    .rate_busy_o(rate_busy_o), .err_o(err_o));

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_width, m_height, m_period, m_rate, m_acc, m_lines, m_cnt, m_busy, m_pend;
  bit m_field, m_upd, m_rstb, m_err, m_inl, m_infr, m_seen;
  localparam int CMASK = (1 << CNT_W) - 1;
  localparam int PMOD  = 1 << PER_W;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_width = 0; m_height = 0; m_period = 0; m_rate = 0; m_acc = 0; m_lines = 0;
      m_cnt = 0; m_busy = 0; m_pend = 0; m_field = 0; m_upd = 0; m_rstb = 0;
      m_err = 0; m_inl = 0; m_infr = 0; m_seen = 0;
    end else begin
      int pop, sum, lsum, per;
      bit act, fact, eol_ok, zero, eset, hold, was_busy;
      pop = $countones(valid);
      per = m_cnt % PMOD;
      zero = m_seen && sol && per == 0;
      eset = (sol && m_inl) || zero;
      hold = m_err || eset;
      act = m_inl || sol;
      eol_ok = eol && act;
      sum = ((sol ? 0 : m_acc) + (act ? pop : 0)) & CMASK;
      if (eol_ok && !hold) m_width = sum;
      m_acc = sum;
      m_inl = act && !eol;
      fact = m_infr || sof;
      lsum = ((sof ? 0 : m_lines) + ((eol_ok && fact) ? 1 : 0)) & CMASK;
      m_upd = 0;
      if (eof && fact && !hold) begin m_height = lsum; m_upd = 1; end
      m_lines = lsum;
      m_infr = fact && !eof;
      if (sof && !hold) m_field = fld;
      if (sol && m_seen && !hold) m_period = per;
      m_rstb = 0;
      was_busy = m_busy > 0;
      if (was_busy) begin
        m_busy--;
        if (m_busy == 0 && !hold) begin m_rate = m_pend; m_rstb = 1; end
      end else if (sol && m_seen && !hold && per != 0) begin
        m_pend = int'((longint'(ht) * 32768) / per);
        m_busy = DIV_W;
      end
      m_cnt = sol ? 1 : (m_cnt + 1) % PMOD;
      if (sol) m_seen = 1;
      if (eset) m_err = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R1 width", width_o, m_width);
      check("R3 height", height_o, m_height);
      check("R3 upd_stb", upd_stb_o, m_upd);
      check("R4 field", field_o, m_field);
      check("R5 period", period_o, m_period);
      check("R6 rate", rate_o, m_rate);
      check("R6 rate_stb", rate_stb_o, m_rstb);
      check("R6 busy", rate_busy_o, m_busy > 0);
      check("R7 err", err_o, m_err);
    end
  end

  task automatic beat(logic [LANES-1:0] v, bit sl, bit el, bit sf, bit ef, bit fd);
    @(posedge clk); #1;
    valid = v; sol = sl; eol = el; sof = sf; eof = ef; fld = fd;
  endtask

  task automatic send_line(int npix, int gap, bit is_sof, bit is_eof, bit fd, int idle);
    int nb = (npix + LANES - 1) / LANES;
    for (int b = 0; b < nb; b++) begin
      logic [LANES-1:0] v;
      v = (b == nb - 1 && (npix % LANES) != 0) ? LANES'((1 << (npix % LANES)) - 1) : '1;
      beat(v, b == 0, b == nb - 1, is_sof && b == 0, is_eof && b == nb - 1, fd);
      if (b == 0 && nb > 1) for (int g = 0; g < gap; g++) beat('0, 0, 0, 0, 0, !fd);
    end
    for (int i = 0; i < idle; i++) beat('1, 0, 0, 0, 0, !fd); // outside line: ignored
  endtask

  task automatic send_frame(int lines, int npix, int gap, bit fd, int idle);
    for (int l = 0; l < lines; l++) send_line(npix, gap, l == 0, l == lines - 1, fd, idle);
  endtask

  task automatic do_reset();
    cmp_on = 0;
    @(posedge clk); #1;
    valid = 0; sol = 0; eol = 0; sof = 0; eof = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R9 width", width_o, 0);
    check("R9 height", height_o, 0);
    check("R9 rate", rate_o, 0);
    check("R9 period", period_o, 0);
    check("R9 err", err_o, 0);
    check("R9 flags", {field_o, upd_stb_o, rate_stb_o, rate_busy_o}, 0);
    cmp_on = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R8 passthrough
    attr = 16'hA5C3; #1 check("R8 attr", attr_o, 16'hA5C3);
    attr = 16'h0F0F; #1 check("R8 attr", attr_o, 16'h0F0F);
    // top field frame, 13 px lines with gap, period 25
    ht = 8'd100;
    send_frame(3, 13, 1, 1, 20);
    @(negedge clk);
    check("R2 width 13 partial beat", width_o, 13);
    check("R3 height 3", height_o, 3);
    check("R4 field top", field_o, 1);
    // bottom field, 14 px, new htotal
    ht = 8'd200;
    send_frame(2, 14, 3, 0, 30);
    @(negedge clk);
    check("R2 width 14 partial beat", width_o, 14);
    check("R4 field bottom", field_o, 0);
    // exact multiple width
    send_frame(4, 8, 0, 1, 25);
    // one-beat lines with every marker in the same cycle
    send_frame(1, 1, 0, 0, 28);
    @(negedge clk);
    check("R1 one-beat line", width_o, 1);
    check("R3 one-line frame", height_o, 1);
    // short periods: starts dropped while divider busy
    ht = 8'd37;
    send_frame(6, 5, 0, 1, 2);
    repeat (30) beat('0, 0, 0, 0, 0, 0);
    // R7 line start inside an open line
    beat('1, 1, 0, 0, 0, 0);
    beat('1, 0, 0, 0, 0, 0);
    beat('1, 1, 0, 0, 0, 0);
    beat('1, 0, 1, 0, 0, 0);
    send_frame(2, 6, 0, 0, 20);
    @(negedge clk);
    check("R7 err after nested sol", err_o, 1);
    check("R7 width held", width_o, 5);
    // R7 zero period after wrap
    do_reset();
    ht = 8'd64;
    send_line(8, 0, 1, 0, 1, 38);  // period 40
    send_line(8, 0, 0, 0, 1, 62);  // period 64 -> wraps to 0
    send_line(7, 0, 0, 1, 1, 10);
    @(negedge clk);
    check("R7 err on zero period", err_o, 1);
    check("R7 period held", period_o, 40);
    check("R7 height not updated", height_o, 0);
    repeat (5) beat('0, 0, 0, 0, 0, 0);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule